// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a watchdog counter with two escalation levels. While the run bit is set, a 32-bit count climbs by one each clock. When the count reaches a first programmable limit, the block sets a sticky warning flag that drives an interrupt line. When it reaches a second programmable limit, it raises a reset request that stays up until the block itself is reset. Software keeps the system alive by writing zero to the count register ("petting"). The count is never lost to wrap-around, because it saturates at all-ones.

All state is reached through a simple single-cycle 32-bit register port: a write strobe, a word address, write data and a combinational read-data bus. A one-way write-enable bit lets boot software freeze the run bit and both limits. After that, only a reset can change them. The count register stays writable, so petting still works after the freeze.

Register words (3-bit address): 0 = control (bit 0 run), 1 = config write-enable (bit 0), 2 = count, 3 = warning limit, 4 = reset limit, 5 = status (bit 0 warning flag, write 1 to clear; bit 1 reset request, read-only). Other addresses read as zero and ignore writes.

Top module: `wdog_bb_top`

## Requirements
- R1: After reset, the control, count, both limits and both status bits read zero, the write-enable word (address 1) reads 1, and both outputs are low.
- R2: The count increments by exactly one per clock while control bit 0 (address 0) is 1, and holds its value while that bit is 0.
- R3: The count saturates at 0xFFFF_FFFF and never wraps to zero on its own.
- R4: A write to address 2 loads the written value into the count on that clock edge and takes priority over the increment, so writing zero pets the watchdog.
- R5: Writing 0 to bit 0 of address 1 clears the write-enable bit. Writing 1 never sets it again before reset.
- R6: While the write-enable bit is 0, writes to addresses 0, 3 and 4 leave those registers unchanged, and writes to address 2 still load the count.
- R7: When run is 1 and count >= warning limit, status bit 0 is 1 one clock later, and the interrupt output follows status bit 0.
- R8: Writing 1 to bit 0 of address 5 clears the warning flag on that edge, unless the warning condition holds in the same cycle, in which case the flag stays set.
- R9: When run is 1 and count >= reset limit, the reset-request output and status bit 1 go high one clock later and stay high until reset, whatever is written.
- R10: While run is 0, neither limit comparison sets any flag, even if the count is above both limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| bark_irq_o | output | 1 | Warning interrupt (status bit 0) |
| bite_req_o | output | 1 | Sticky reset request |

## Verification
A register write takes effect on the clock edge that samples it, and read data reflects it straight after that edge. The flags are registered comparisons of the count as it stood before the edge, so each flag is due one clock after the count first meets its limit. The count is therefore visible one cycle before the flag it triggers. The reference model applies every write and comparison at the same edge using the pre-edge values. Outputs and read data are compared late in each cycle, well after inputs settle, so each result is checked in exactly the cycle it is due.

// File: rtl/wdog_bb_pkg.sv
package wdog_bb_pkg;
    parameter int DW     = 32;
    parameter int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_WREN  = 3'd1,
        A_COUNT = 3'd2,
        A_WARN  = 3'd3,
        A_KILL  = 3'd4,
        A_STAT  = 3'd5
    } wdog_addr_e;

    localparam int N_LIMITS = 2;
    localparam int LIM_WARN = 0;
    localparam int LIM_KILL = 1;
endpackage

// File: rtl/wdog_bb_cfg.sv
module wdog_bb_cfg
    import wdog_bb_pkg::*;
#(
    parameter int W = DW
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      wdata_i,
    output logic              run_o,
    output logic              wren_o,
    output logic [W-1:0]      warn_lim_o,
    output logic [W-1:0]      kill_lim_o
);
    typedef struct packed {
        logic         run;
        logic         wren;
        logic [W-1:0] warn_lim;
        logic [W-1:0] kill_lim;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            case (addr_i)
                A_WREN:  if (!wdata_i[0]) cfg_d.wren = 1'b0;
                A_CTRL:  if (cfg_q.wren) cfg_d.run = wdata_i[0];
                A_WARN:  if (cfg_q.wren) cfg_d.warn_lim = wdata_i;
                A_KILL:  if (cfg_q.wren) cfg_d.kill_lim = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '{run: 1'b0, wren: 1'b1, warn_lim: '0, kill_lim: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign run_o      = cfg_q.run;
    assign wren_o     = cfg_q.wren;
    assign warn_lim_o = cfg_q.warn_lim;
    assign kill_lim_o = cfg_q.kill_lim;
endmodule

// File: rtl/wdog_bb_counter.sv
module wdog_bb_counter
    import wdog_bb_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (run_i && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_bb_cmp.sv
module wdog_bb_cmp
    import wdog_bb_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] warn_lim_i,
    input  logic [W-1:0] kill_lim_i,
    input  logic         warn_clr_i,
    output logic         warn_o,
    output logic         kill_o
);
    typedef struct packed {
        logic warn;
        logic kill;
    } flags_t;

    logic [W-1:0]        lim [N_LIMITS];
    logic [N_LIMITS-1:0] hit;
    flags_t              fl_d, fl_q;

    assign lim[LIM_WARN] = warn_lim_i;
    assign lim[LIM_KILL] = kill_lim_i;

    for (genvar g = 0; g < N_LIMITS; g++) begin : g_cmp
        assign hit[g] = run_i && (cnt_i >= lim[g]);
    end

    always_comb begin
        fl_d = fl_q;
        if (warn_clr_i)    fl_d.warn = 1'b0;
        if (hit[LIM_WARN]) fl_d.warn = 1'b1;
        if (hit[LIM_KILL]) fl_d.kill = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fl_q <= '0;
        else         fl_q <= fl_d;
    end

    assign warn_o = fl_q.warn;
    assign kill_o = fl_q.kill;
endmodule

// File: rtl/wdog_bb_top.sv
module wdog_bb_top
    import wdog_bb_pkg::*;
#(
    parameter int W = DW
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      wdata_i,
    output logic [W-1:0]      rdata_o,
    output logic              bark_irq_o,
    output logic              bite_req_o
);
    logic         run_q;
    logic         wren_q;
    logic [W-1:0] warn_lim_q;
    logic [W-1:0] kill_lim_q;
    logic [W-1:0] cnt_q;
    logic         cnt_load;
    logic         warn_clr;

    assign cnt_load = wr_en_i && (addr_i == A_COUNT);
    assign warn_clr = wr_en_i && (addr_i == A_STAT) && wdata_i[0];

    wdog_bb_cfg #(.W(W)) u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .run_o      (run_q),
        .wren_o     (wren_q),
        .warn_lim_o (warn_lim_q),
        .kill_lim_o (kill_lim_q)
    );

    wdog_bb_counter #(.W(W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run_q),
        .load_i     (cnt_load),
        .load_val_i (wdata_i),
        .cnt_o      (cnt_q)
    );

    wdog_bb_cmp #(.W(W)) u_cmp (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run_q),
        .cnt_i      (cnt_q),
        .warn_lim_i (warn_lim_q),
        .kill_lim_i (kill_lim_q),
        .warn_clr_i (warn_clr),
        .warn_o     (bark_irq_o),
        .kill_o     (bite_req_o)
    );

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL:  rdata_o[0] = run_q;
            A_WREN:  rdata_o[0] = wren_q;
            A_COUNT: rdata_o    = cnt_q;
            A_WARN:  rdata_o    = warn_lim_q;
            A_KILL:  rdata_o    = kill_lim_q;
            A_STAT:  rdata_o[1:0] = {bite_req_o, bark_irq_o};
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/wdog_bb_chk.sv
module wdog_bb_chk #(
    parameter int W = 32
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         run,
    input logic         wren,
    input logic [W-1:0] cnt,
    input logic         cnt_load,
    input logic [W-1:0] warn_lim,
    input logic [W-1:0] kill_lim,
    input logic         bark,
    input logic         bite
);
    a_r3_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt == {W{1'b1}} && !cnt_load) |=> (cnt == {W{1'b1}}));

    a_r2_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run && !cnt_load) |=> $stable(cnt));

    a_r5_lock_one_way: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wren |=> !wren);

    a_r6_locked_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wren |=> ($stable(run) && $stable(warn_lim) && $stable(kill_lim)));

    a_r7_bark_raised: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && cnt >= warn_lim) |=> bark);

    a_r9_bite_raised: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && cnt >= kill_lim) |=> bite);

    a_r9_bite_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bite |=> bite);
endmodule

bind wdog_bb_top wdog_bb_chk #(.W(W)) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run      (run_q),
    .wren     (wren_q),
    .cnt      (cnt_q),
    .cnt_load (cnt_load),
    .warn_lim (warn_lim_q),
    .kill_lim (kill_lim_q),
    .bark     (bark_irq_o),
    .bite     (bite_req_o)
);

// File: tb/wdog_bb_top_tb_top.sv
module wdog_bb_top_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  addr_i = 3'd0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        bark_irq_o, bite_req_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk_i = ~clk_i;

    wdog_bb_top dut_i (
        .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
        .rdata_o, .bark_irq_o, .bite_req_o
    );

    // behavioural reference model
    logic [31:0] m_cnt, m_warn, m_kill;
    logic        m_run, m_wren, m_bark, m_bite;
    bit          hw, hk;

    always @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            m_cnt <= 0; m_warn <= 0; m_kill <= 0;
            m_run <= 0; m_wren <= 1; m_bark <= 0; m_bite <= 0;
        end else begin
            hw = m_run && (m_cnt >= m_warn);
            hk = m_run && (m_cnt >= m_kill);
            if (wr_en_i && addr_i == 3'd2) m_cnt <= wdata_i;
            else if (m_run && m_cnt != 32'hFFFF_FFFF) m_cnt <= m_cnt + 1;
            if (wr_en_i && addr_i == 3'd1 && !wdata_i[0]) m_wren <= 0;
            if (wr_en_i && m_wren) begin
                if (addr_i == 3'd0) m_run  <= wdata_i[0];
                if (addr_i == 3'd3) m_warn <= wdata_i;
                if (addr_i == 3'd4) m_kill <= wdata_i;
            end
            if (hw) m_bark <= 1;
            else if (wr_en_i && addr_i == 3'd5 && wdata_i[0]) m_bark <= 0;
            if (hk) m_bite <= 1;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return {31'b0, m_run};
            3'd1: return {31'b0, m_wren};
            3'd2: return m_cnt;
            3'd3: return m_warn;
            3'd4: return m_kill;
            3'd5: return {30'b0, m_bite, m_bark};
            default: return 0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R5";
            3'd2: return "R4";
            3'd3, 3'd4: return "R6";
            3'd5: return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, late in the cycle
    always @(posedge clk_i) begin
        #15;
        if (rst_ni && !done) begin
            chk("R7 bark_irq_o", {31'b0, bark_irq_o}, {31'b0, m_bark});
            chk("R9 bite_req_o", {31'b0, bite_req_o}, {31'b0, m_bite});
            chk(rd_tag(addr_i), rdata_o, exp_rd(addr_i));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk_i);
        wr_en_i = 1; addr_i = a; wdata_i = d;
        @(negedge clk_i);
        wr_en_i = 0; wdata_i = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr_i = a;
        #5;
        v = rdata_o;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        rst_ni = 0; wr_en_i = 0; addr_i = 0; wdata_i = 0;
        idle(2);
        rst_ni = 1;
    endtask

    task automatic summary();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        logic [31:0] v, v2;
        do_reset();
        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 reset read", v, (a == 1) ? 32'd1 : 32'd0);
        end
        chk("R1 outputs", {30'b0, bite_req_o, bark_irq_o}, 0);

        // R10 stopped count above limits raises nothing
        wr(3'd3, 5); wr(3'd4, 6); wr(3'd2, 100);
        idle(4);
        chk("R10 no flags while stopped", {30'b0, bite_req_o, bark_irq_o}, 0);
        // R2 hold while stopped
        rd(3'd2, v);
        chk("R2 hold while stopped", v, 100);

        // R7 / R9 flags after enabling
        wr(3'd0, 1);
        idle(2);
        chk("R7 bark set", {31'b0, bark_irq_o}, 1);
        chk("R9 bite set", {31'b0, bite_req_o}, 1);
        // R8 clear loses to a holding condition
        wr(3'd5, 1);
        chk("R8 set wins over clear", {31'b0, bark_irq_o}, 1);
        wr(3'd0, 0);
        wr(3'd5, 3);
        rd(3'd5, v);
        chk("R8 cleared, R9 bite kept", v, 32'd2);
        idle(3);
        chk("R9 bite sticky", {31'b0, bite_req_o}, 1);

        // R4 petting
        do_reset();
        wr(3'd3, 1000); wr(3'd4, 2000); wr(3'd0, 1);
        idle(50);
        rd(3'd2, v);
        idle(1);
        rd(3'd2, v2);
        chk("R2 increments by one", v2, v + 1);
        wr(3'd2, 0);
        rd(3'd2, v);
        chk("R4 pet loads zero", v, 0);
        chk("R4 no flags after pet", {30'b0, bite_req_o, bark_irq_o}, 0);

        // R7 exact boundary: count reaches warn limit
        wr(3'd2, 995);
        idle(4);
        chk("R7 before limit", {31'b0, bark_irq_o}, 0);
        idle(2);
        chk("R7 after limit", {31'b0, bark_irq_o}, 1);

        // R5 / R6 lock
        wr(3'd1, 1);
        rd(3'd1, v); chk("R5 writing 1 keeps unlocked", v, 1);
        wr(3'd1, 0);
        rd(3'd1, v); chk("R5 locked", v, 0);
        wr(3'd1, 1);
        rd(3'd1, v); chk("R5 lock one-way", v, 0);
        wr(3'd3, 7);
        rd(3'd3, v); chk("R6 warn limit frozen", v, 1000);
        wr(3'd4, 9);
        rd(3'd4, v); chk("R6 kill limit frozen", v, 2000);
        wr(3'd0, 0);
        rd(3'd0, v); chk("R6 run frozen", v, 1);
        wr(3'd2, 0);
        rd(3'd2, v); chk("R6 pet still allowed", v, 0);

        // R3 saturation
        do_reset();
        wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd2, 32'hFFFF_FFFD);
        wr(3'd0, 1);
        idle(6);
        rd(3'd2, v);
        chk("R3 saturates", v, 32'hFFFF_FFFF);
        chk("R9 bite at max", {31'b0, bite_req_o}, 1);

        // a spread of addresses compared by the model
        for (int i = 0; i < 12; i++) begin
            @(negedge clk_i);
            addr_i = 3'(i % 8);
        end
        idle(2);
        summary();
    end
endmodule